// File: doc/BRIEF.md
# Fading Alpha Window Blender

This block lays one rectangular blend window over a raster of pixels. On each pixel clock it takes the current raster position, a frame-start pulse, a video-window enable, a color-key match flag, one graphics pixel and one video pixel (24 bits each, three 8-bit channels). It returns a single registered pixel. Outside the window, and whenever the window is off, the video pixel passes through unchanged. Inside the window, each channel of the two pixels is mixed by an 8-bit alpha weight.

The alpha weight changes by itself from frame to frame. A signed 8-bit step is added to it at every frame start. Once it reaches full scale or zero, it stays there until software reloads it. A reload request is held back until the next frame start, so a frame never changes alpha part way through. When the key flag is set inside the window, the pixel is either replaced by a programmed constant color or left unblended (video passes), depending on an enable.

Software programs the block through a small write port. It has four word selects: key color, control, horizontal bounds and vertical bounds.

Top module: `fade_win_blend`

## Requirements
- R1: After reset every configuration field is zero, `out_valid` and `out_pix` are 0, and the window is off, so each valid pixel leaves as the unchanged video pixel.
- R2: A pixel is inside the window when `x_lo <= hcount < x_hi` and `y_lo <= vcount < y_hi`. The lower bounds are inclusive and the upper bounds are exclusive.
- R3: When `video_win_en` is 0, the output is the video pixel whatever the window enable and position.
- R4: For an active window pixel with no key match, each channel is `(A*g + (255-A)*v)/255` rounded to nearest. A is the alpha in effect and g, v are that channel of `gfx_pix` and `vid_pix`.
- R5: For an active window pixel with `key_match`=1 and the key-color enable set, the output is the programmed 24-bit key color.
- R6: For an active window pixel with `key_match`=1 and the key-color enable clear, no blending is done and the video pixel is output.
- R7: The output pixel has one clock of latency, and `out_valid` is `pix_valid` delayed by one clock.
- R8: On a `frame_start` cycle with no pending reload and no saturation hold, the signed step is added to alpha. Alpha changes in no other cycle. The updated alpha already applies to the pixel presented with `frame_start`.
- R9: An increase that reaches or passes 255 sets alpha to 255. A decrease that reaches or passes 0 sets alpha to 0. In both cases alpha then holds on every later frame, even if the step changes, until a reload.
- R10: Writing the control word with the load bit set does not change alpha at once. At the next `frame_start` the programmed alpha becomes active instead of the step being applied, and the hold is cleared.
- R11: Write port selects: 0 = key color (bits 23:0 color, bit 24 enable); 1 = control (bits 7:0 alpha, 15:8 signed step, bit 16 window enable, bit 17 load, which is not stored); 2 = horizontal bounds (10:0 lower, 26:16 upper); 3 = vertical bounds, laid out the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Configuration word select |
| wr_data | input | 27 | Configuration write data |
| pix_valid | input | 1 | Input pixel qualifier |
| frame_start | input | 1 | Pulse marking the first pixel of a frame |
| hcount | input | 11 | Horizontal raster position |
| vcount | input | 11 | Vertical raster position |
| video_win_en | input | 1 | Video window enable; gates the blend window |
| key_match | input | 1 | Color key matched at this pixel |
| gfx_pix | input | 24 | Graphics pixel |
| vid_pix | input | 24 | Video pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Blended, overridden or passed pixel |

## Verification
Several rules are checked by the assertions on every cycle: the valid delay, the video pass-through when the video window is off, both key-match outcomes, alpha staying put between frame starts and while held, the hold only occurring at 0 or 255, and a reload landing exactly on the programmed value. Other behaviour can only be shown by the bench's scenarios. That covers the rounded blend values, the window edges on all four sides, the fade from 250 upward into the 255 clamp and from 120 downward into the 0 clamp, and a reload that stays deferred across pixels and then wins over a step at the frame start. The bench reads alpha through the normal output by blending full-scale graphics over black video.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int CH_W   = 8;
  localparam int NCH    = 3;
  localparam int PIX_W  = CH_W * NCH;
  localparam int POS_W  = 11;
  localparam int HI_LSB = 16;
  localparam int DATA_W = HI_LSB + POS_W;
  localparam int CH_MAX = (1 << CH_W) - 1;
  localparam int WIN_BIT  = 2 * CH_W;
  localparam int LOAD_BIT = 2 * CH_W + 1;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_XPOS = 2'd2,
    SEL_YPOS = 2'd3
  } sel_e;

  typedef struct packed {
    logic [PIX_W-1:0] key_color;
    logic             key_en;
    logic [CH_W-1:0]  alpha_init;
    logic [CH_W-1:0]  step;
    logic             win_en;
    logic [POS_W-1:0] x_lo;
    logic [POS_W-1:0] x_hi;
    logic [POS_W-1:0] y_lo;
    logic [POS_W-1:0] y_hi;
  } cfg_t;

  // rounded weighted mix of one channel
  function automatic logic [CH_W-1:0] mix_ch(input logic [CH_W-1:0] a,
                                             input logic [CH_W-1:0] g,
                                             input logic [CH_W-1:0] v);
    int n;
    n = int'(a) * int'(g) + (CH_MAX - int'(a)) * int'(v) + CH_MAX / 2;
    return CH_W'(n / CH_MAX);
  endfunction

  // one frame step: returns {saturated, new_alpha}
  function automatic logic [CH_W:0] step_alpha(input logic [CH_W-1:0] a,
                                               input logic [CH_W-1:0] s);
    logic signed [CH_W+1:0] sum;
    sum = $signed({2'b00, a}) + $signed({{2{s[CH_W-1]}}, s});
    if (!s[CH_W-1] && (s != '0) && (sum >= CH_MAX))
      return {1'b1, CH_W'(CH_MAX)};
    else if (s[CH_W-1] && (sum <= 0))
      return {1'b1, {CH_W{1'b0}}};
    else
      return {1'b0, sum[CH_W-1:0]};
  endfunction
endpackage

// File: rtl/fwb_regs.sv
module fwb_regs
  import fwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic              load_req
);
  sel_e sel;
  assign sel = sel_e'(wr_sel);

  assign load_req = wr_en && (sel == SEL_CTRL) && wr_data[LOAD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_KEY: begin
          cfg.key_color <= wr_data[PIX_W-1:0];
          cfg.key_en    <= wr_data[PIX_W];
        end
        SEL_CTRL: begin
          cfg.alpha_init <= wr_data[CH_W-1:0];
          cfg.step       <= wr_data[CH_W +: CH_W];
          cfg.win_en     <= wr_data[WIN_BIT];
        end
        SEL_XPOS: begin
          cfg.x_lo <= wr_data[POS_W-1:0];
          cfg.x_hi <= wr_data[HI_LSB +: POS_W];
        end
        default: begin
          cfg.y_lo <= wr_data[POS_W-1:0];
          cfg.y_hi <= wr_data[HI_LSB +: POS_W];
        end
      endcase
    end
  end
endmodule

// File: rtl/fwb_fader.sv
module fwb_fader
  import fwb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            load_req,
  input  logic [CH_W-1:0] alpha_init,
  input  logic [CH_W-1:0] step,
  output logic [CH_W-1:0] alpha_use
);
  logic [CH_W-1:0] alpha_q, alpha_nx;
  logic            hold_q, hold_nx, pend_q;
  logic [CH_W:0]   stepped;
  logic            apply_load, apply_step;

  assign apply_load = frame_start && pend_q;
  assign apply_step = frame_start && !pend_q && !hold_q;
  assign stepped    = step_alpha(alpha_q, step);

  always_comb begin
    alpha_nx = alpha_q;
    hold_nx  = hold_q;
    if (apply_load) begin
      alpha_nx = alpha_init;
      hold_nx  = 1'b0;
    end else if (apply_step) begin
      alpha_nx = stepped[CH_W-1:0];
      hold_nx  = stepped[CH_W];
    end
  end

  // new frame's alpha already serves the frame-start pixel
  assign alpha_use = alpha_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alpha_q <= '0;
      hold_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      alpha_q <= alpha_nx;
      hold_q  <= hold_nx;
      pend_q  <= load_req || (pend_q && !frame_start);
    end
  end

  a_r8_alpha_only_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(alpha_q));
  a_r9_hold_keeps_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !apply_load) |=> $stable(alpha_q));
  a_r9_hold_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> ((alpha_q == '0) || (alpha_q == CH_W'(CH_MAX))));
  a_r10_reload_lands: assert property (@(posedge clk) disable iff (!rst_n)
    apply_load |=> ((alpha_q == $past(alpha_init)) && !hold_q));
endmodule

// File: rtl/fwb_window.sv
module fwb_window
  import fwb_pkg::*;
(
  input  logic [POS_W-1:0] hcount,
  input  logic [POS_W-1:0] vcount,
  input  logic [POS_W-1:0] x_lo,
  input  logic [POS_W-1:0] x_hi,
  input  logic [POS_W-1:0] y_lo,
  input  logic [POS_W-1:0] y_hi,
  input  logic             win_en,
  input  logic             video_win_en,
  output logic             active
);
  logic in_x, in_y;
  assign in_x   = (hcount >= x_lo) && (hcount < x_hi);
  assign in_y   = (vcount >= y_lo) && (vcount < y_hi);
  assign active = win_en && video_win_en && in_x && in_y;
endmodule

// File: rtl/fwb_mix.sv
module fwb_mix
  import fwb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             active,
  input  logic             key_match,
  input  logic             key_en,
  input  logic [PIX_W-1:0] key_color,
  input  logic [CH_W-1:0]  alpha,
  input  logic [PIX_W-1:0] gfx_pix,
  input  logic [PIX_W-1:0] vid_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  logic [PIX_W-1:0] blended, pix_nx;
  logic             key_force, key_pass;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign blended[c*CH_W +: CH_W] =
      mix_ch(alpha, gfx_pix[c*CH_W +: CH_W], vid_pix[c*CH_W +: CH_W]);
  end

  assign key_force = active && key_match && key_en;
  assign key_pass  = active && key_match && !key_en;

  always_comb begin
    if (!active || key_pass) pix_nx = vid_pix;
    else if (key_force)      pix_nx = key_color;
    else                     pix_nx = blended;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= pix_valid;
      out_pix   <= pix_nx;
    end
  end

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  a_r7_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  a_r5_key_color: assert property (@(posedge clk) disable iff (!rst_n)
    key_force |=> (out_pix == $past(key_color)));
  a_r6_key_no_blend: assert property (@(posedge clk) disable iff (!rst_n)
    key_pass |=> (out_pix == $past(vid_pix)));
endmodule

// File: rtl/fade_win_blend.sv
module fade_win_blend
  import fwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pix_valid,
  input  logic              frame_start,
  input  logic [POS_W-1:0]  hcount,
  input  logic [POS_W-1:0]  vcount,
  input  logic              video_win_en,
  input  logic              key_match,
  input  logic [PIX_W-1:0]  gfx_pix,
  input  logic [PIX_W-1:0]  vid_pix,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);
  cfg_t            cfg;
  logic            load_req;
  logic [CH_W-1:0] alpha_use;
  logic            active;

  fwb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg(cfg), .load_req(load_req)
  );

  fwb_fader u_fader (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .load_req(load_req),
    .alpha_init(cfg.alpha_init), .step(cfg.step), .alpha_use(alpha_use)
  );

  fwb_window u_window (
    .hcount(hcount), .vcount(vcount), .x_lo(cfg.x_lo), .x_hi(cfg.x_hi),
    .y_lo(cfg.y_lo), .y_hi(cfg.y_hi), .win_en(cfg.win_en),
    .video_win_en(video_win_en), .active(active)
  );

  fwb_mix u_mix (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .active(active),
    .key_match(key_match), .key_en(cfg.key_en), .key_color(cfg.key_color),
    .alpha(alpha_use), .gfx_pix(gfx_pix), .vid_pix(vid_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  a_r3_video_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !video_win_en |=> (out_pix == $past(vid_pix)));
endmodule

// File: tb/fade_win_blend_bench.sv
module fade_win_blend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [26:0] wr_data = '0;
  logic        pix_valid = 1'b0, frame_start = 1'b0;
  logic [10:0] hcount = '0, vcount = '0;
  logic        video_win_en = 1'b0, key_match = 1'b0;
  logic [23:0] gfx_pix = '0, vid_pix = '0;
  logic        out_valid;
  logic [23:0] out_pix;

  always #10 clk = ~clk;

  fade_win_blend u_fade_win_blend (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pix_valid(pix_valid), .frame_start(frame_start), .hcount(hcount),
    .vcount(vcount), .video_win_en(video_win_en), .key_match(key_match),
    .gfx_pix(gfx_pix), .vid_pix(vid_pix), .out_valid(out_valid), .out_pix(out_pix)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];

  // reference state
  int m_alpha = 0, m_init = 0, m_step = 0;
  bit m_hold = 0, m_pend = 0, m_win = 0, m_key_en = 0;
  int m_key = 0, m_xl = 0, m_xh = 0, m_yl = 0, m_yh = 0;

  function automatic int ref_ch(int a, int g, int v);
    int n = a * g + (255 - a) * v;
    return (2 * n + 255) / 510;
  endfunction

  function automatic logic [26:0] ctrl_word(bit ld, bit win, int st, int a);
    logic [26:0] d = '0;
    logic [31:0] s32 = st;
    logic [31:0] a32 = a;
    d[7:0]  = a32[7:0];
    d[15:8] = s32[7:0];
    d[16]   = win;
    d[17]   = ld;
    return d;
  endfunction

  function automatic logic [26:0] bounds(int lo, int hi);
    logic [26:0] d = '0;
    logic [31:0] l32 = lo;
    logic [31:0] h32 = hi;
    d[10:0]  = l32[10:0];
    d[26:16] = h32[10:0];
    return d;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [26:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    pix_valid = 1'b0; frame_start = 1'b0;
    case (sel)
      2'd0: begin m_key = int'(d[23:0]); m_key_en = d[24]; end
      2'd1: begin
        m_init = int'(d[7:0]); m_step = int'($signed(d[15:8]));
        m_win = d[16]; if (d[17]) m_pend = 1;
      end
      2'd2: begin m_xl = int'(d[10:0]); m_xh = int'(d[26:16]); end
      default: begin m_yl = int'(d[10:0]); m_yh = int'(d[26:16]); end
    endcase
    exp_q.push_back(25'd0); tag_q.push_back("R7");
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    wr_en = 1'b0; pix_valid = 1'b0; frame_start = 1'b0;
    exp_q.push_back(25'd0); tag_q.push_back(tag);
  endtask

  task automatic px(input bit fs, input int h, input int v, input bit vwe,
                    input bit key, input logic [23:0] g, input logic [23:0] vd,
                    input string tag);
    logic [23:0] e;
    bit act;
    int t;
    @(negedge clk);
    wr_en = 1'b0; pix_valid = 1'b1; frame_start = fs;
    hcount = 11'(h); vcount = 11'(v); video_win_en = vwe; key_match = key;
    gfx_pix = g; vid_pix = vd;
    if (fs) begin
      if (m_pend) begin
        m_alpha = m_init; m_hold = 0; m_pend = 0;
      end else if (!m_hold && m_step != 0) begin
        t = m_alpha + m_step;
        if (m_step > 0 && t >= 255)      begin m_alpha = 255; m_hold = 1; end
        else if (m_step < 0 && t <= 0)   begin m_alpha = 0;   m_hold = 1; end
        else m_alpha = t;
      end
    end
    act = m_win && vwe && h >= m_xl && h < m_xh && v >= m_yl && v < m_yh;
    if (!act) e = vd;
    else if (key) e = m_key_en ? 24'(m_key) : vd;
    else
      for (int c = 0; c < 3; c++)
        e[c*8 +: 8] = 8'(ref_ch(m_alpha, int'(g[c*8 +: 8]), int'(vd[c*8 +: 8])));
    exp_q.push_back({1'b1, e}); tag_q.push_back(tag);
  endtask

  // monitor: compares one item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [24:0] ex;
      string tg;
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      tests++;
      if (out_valid !== ex[24] || (ex[24] && out_pix !== ex[23:0])) begin
        fails++;
        $display("FAIL %s: got valid=%0b pix=%06h, expected valid=%0b pix=%06h",
                 tg, out_valid, out_pix, ex[24], ex[23:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam logic [23:0] WHITE = 24'hFFFFFF, BLACK = 24'h000000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || out_pix !== 24'h0) begin
      fails++;
      $display("FAIL R1: got valid=%0b pix=%06h, expected valid=0 pix=000000", out_valid, out_pix);
    end
    // R1: window off after reset
    px(0, 5, 5, 1, 0, 24'h112233, 24'h445566, "R1");
    px(1, 0, 0, 1, 0, WHITE, 24'h0A0B0C, "R1");
    // R11: program bounds and control word with load
    wr(2'd2, bounds(10, 20));
    wr(2'd3, bounds(5, 8));
    wr(2'd1, ctrl_word(1, 1, 0, 8'h80));
    px(0, 12, 6, 1, 0, WHITE, BLACK, "R10");   // load still deferred
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R10");   // 0x80 active now
    // R2 edges
    px(0, 9, 5, 1, 0, WHITE, 24'h123456, "R2");
    px(0, 19, 7, 1, 0, WHITE, 24'h123456, "R2");
    px(0, 20, 6, 1, 0, WHITE, 24'h123456, "R2");
    px(0, 12, 8, 1, 0, WHITE, 24'h123456, "R2");
    px(0, 12, 4, 1, 0, WHITE, 24'h123456, "R11");
    // R3 gate
    px(0, 12, 6, 0, 0, WHITE, 24'h6789AB, "R3");
    // R4 blends
    px(0, 11, 6, 1, 0, 24'hC81E64, 24'h3250FA, "R4");
    px(0, 13, 6, 1, 0, 24'h01FF7F, 24'hFE0080, "R4");
    // R6 then R5
    px(0, 14, 6, 1, 1, 24'hC81E64, 24'h3250FA, "R6");
    wr(2'd0, {2'b00, 1'b1, 24'hA5C3F0});
    px(0, 14, 6, 1, 1, 24'hC81E64, 24'h3250FA, "R5");
    px(0, 30, 6, 1, 1, 24'hC81E64, 24'h3250FA, "R5");
    idle("R7");
    px(0, 15, 6, 1, 0, 24'h204060, 24'hE0C0A0, "R7");
    // fade upward to the clamp
    wr(2'd1, ctrl_word(1, 1, 3, 250));
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R10");  // 250
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R8");   // 253
    px(0, 11, 5, 1, 0, WHITE, BLACK, "R8");   // 253 mid-frame
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R9");   // 255 clamp
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R9");   // held
    wr(2'd1, ctrl_word(0, 1, -100, 250));
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R9");   // held despite new step
    wr(2'd1, ctrl_word(1, 1, -100, 120));
    px(0, 10, 5, 1, 0, WHITE, BLACK, "R10");  // still 255
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R10");  // 120, step skipped
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R8");   // 20
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R9");   // 0 clamp
    px(1, 10, 5, 1, 0, WHITE, BLACK, "R9");   // held at 0
    idle("R7");
    idle("R7");
    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule